// File: doc/BRIEF.md
# Twelve-Line GPIO Controller with Latched Level Interrupts

This block controls twelve general-purpose pins through a small register window. Eight 32-bit registers are selected by a 3-bit word index, so register N sits at byte offset 4·N. Software sets an output value and a drive-enable for each pin. The pad logic outside uses the pair `pin_out`/`pin_oe` and leaves a pin floating while its drive-enable is 0. Every pin is also sampled through a two-flop synchronizer. The synchronized level can be read back, and it feeds the interrupt logic.

Each line has a polarity bit that selects active-high or active-low level detection. While a line's level condition holds, its pending flag in the status register is set. The flag stays set after the condition goes away, until software writes a 1 to that bit. If the condition still holds in the cycle of the clear, the flag stays set. The enabled pending flags are combined into a single level interrupt output. A 32-bit mux-control word is held for neighbouring pad logic and has no effect inside this block.

Top module: `pinio_ctrl`

## Requirements
- R1: After a synchronous reset every register reads 0, `pin_out`, `pin_oe` and `bus_rdata` are 0, and `irq` is low.
- R2: Word 0 holds the output values and word 1 holds the drive-enables, one bit per pin in bits 11..0. A write to either word is visible on `pin_out`/`pin_oe` after the next clock edge, and bits 31..12 read back as 0.
- R3: Word 2 returns the pin levels after two synchronizer flops, in bits 11..0 with zeros above. A write to word 2 has no effect.
- R4: Lines 0..7 take their polarity from bit 4·n of word 4. Lines 8..11 take theirs from bit 4·(n−8) of word 6. A polarity bit of 0 means active-high and 1 means active-low. All other bits of these words read as 0.
- R5: A line's pending flag in word 3 (bit n) is set on the clock edge after its synchronized level matches its polarity. The flag stays set after the level changes back.
- R6: Writing word 3 clears each pending flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. A flag whose line is still active at that edge remains set.
- R7: Word 5 is the enable mask, where 1 unmasks line n. `irq` is high exactly when some line is both pending and enabled. Masked flags are still visible in word 3.
- R8: Word 7 is a full 32-bit read/write register with no effect inside the block.
- R9: A read request returns its data on `bus_rdata` after the next clock edge. `bus_rdata` holds its value in cycles with no read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 12 | Asynchronous pin levels |
| pin_out | output | 12 | Output values toward the pads |
| pin_oe | output | 12 | Per-pin drive-enable toward the pads |
| irq | output | 1 | Level interrupt: some pending line is enabled |

## Verification
Register writes and their effect on `pin_out`/`pin_oe` are due one edge after the write strobe. Read data is due one edge after the read strobe. A pin change reaches the input register after two edges and the pending flag after three. `irq` follows a change of status or enable in the same cycle. The bench drives inputs on the falling edge and steps a behavioural model on each rising edge. It compares every output 2 ns after that edge, so each result is checked at the first cycle in which it is due. Directed sequences also check the held flags, the clear-while-active case, masking and the per-bank polarity bits against hand-computed values.

// File: rtl/pinio_pkg.sv
`timescale 1ns/1ps
package pinio_pkg;

    localparam int BUS_W          = 32;
    localparam int IDX_W          = 3;
    localparam int LINES_PER_BANK = 8;
    localparam int POL_STRIDE     = 4;

    typedef enum logic [IDX_W-1:0] {
        REG_DOUT  = 3'd0,
        REG_OE    = 3'd1,
        REG_IN    = 3'd2,
        REG_STAT  = 3'd3,
        REG_POL0  = 3'd4,
        REG_EN    = 3'd5,
        REG_POL1  = 3'd6,
        REG_MUX   = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        reg_idx_e         idx;
        logic [BUS_W-1:0] data;
    } bus_req_t;

    // number of lines whose polarity lives in the given bank
    function automatic int bank_lines(int npins, int bank);
        int rest;
        rest = npins - bank * LINES_PER_BANK;
        if (rest < 0)
            return 0;
        if (rest > LINES_PER_BANK)
            return LINES_PER_BANK;
        return rest;
    endfunction

endpackage

// File: rtl/pinio_sync.sv
`timescale 1ns/1ps
module pinio_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++)
                stage[s] <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < STAGES; s++)
                stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/pinio_irq.sv
`timescale 1ns/1ps
module pinio_irq #(
    parameter int NUM_PINS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [NUM_PINS-1:0] pol,
    input  logic [NUM_PINS-1:0] clr_mask,
    output logic [NUM_PINS-1:0] status_q
);

    logic [NUM_PINS-1:0] hit;

    // per-line level condition: polarity 1 inverts the sense
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_line
        assign hit[g] = lvl[g] ^ pol[g];
    end

    always_ff @(posedge clk) begin
        if (rst)
            status_q <= '0;
        else
            status_q <= (status_q & ~clr_mask) | hit;
    end

endmodule

// File: rtl/pinio_regs.sv
`timescale 1ns/1ps
module pinio_regs
    import pinio_pkg::*;
#(
    parameter int NUM_PINS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [IDX_W-1:0]    bus_word,
    input  logic [BUS_W-1:0]    bus_wdata,
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [NUM_PINS-1:0] status_q,
    output logic [NUM_PINS-1:0] dout_q,
    output logic [NUM_PINS-1:0] oe_q,
    output logic [NUM_PINS-1:0] en_q,
    output logic [NUM_PINS-1:0] pol_q,
    output logic [BUS_W-1:0]    mux_q,
    output logic [NUM_PINS-1:0] clr_mask,
    output logic [BUS_W-1:0]    rdata
);

    localparam int L0 = bank_lines(NUM_PINS, 0);
    localparam int L1 = bank_lines(NUM_PINS, 1);

    bus_req_t         req;
    logic [BUS_W-1:0] rd_val;
    logic [BUS_W-1:0] pol0_view;
    logic [BUS_W-1:0] pol1_view;

    assign req.wr   = bus_sel & bus_we;
    assign req.rd   = bus_sel & ~bus_we;
    assign req.idx  = reg_idx_e'(bus_word);
    assign req.data = bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            oe_q   <= '0;
            en_q   <= '0;
            pol_q  <= '0;
            mux_q  <= '0;
        end else if (req.wr) begin
            case (req.idx)
                REG_DOUT: dout_q <= req.data[NUM_PINS-1:0];
                REG_OE:   oe_q   <= req.data[NUM_PINS-1:0];
                REG_EN:   en_q   <= req.data[NUM_PINS-1:0];
                REG_POL0: begin
                    for (int i = 0; i < L0; i++)
                        pol_q[i] <= req.data[POL_STRIDE*i];
                end
                REG_POL1: begin
                    for (int i = 0; i < L1; i++)
                        pol_q[L0+i] <= req.data[POL_STRIDE*i];
                end
                REG_MUX:  mux_q  <= req.data;
                default:  ;
            endcase
        end
    end

    assign clr_mask = (req.wr && req.idx == REG_STAT) ? req.data[NUM_PINS-1:0] : '0;

    // spread the packed polarity bits back onto their nibble positions
    always_comb begin
        pol0_view = '0;
        pol1_view = '0;
        for (int i = 0; i < L0; i++)
            pol0_view[POL_STRIDE*i] = pol_q[i];
        for (int i = 0; i < L1; i++)
            pol1_view[POL_STRIDE*i] = pol_q[L0+i];
    end

    always_comb begin
        case (req.idx)
            REG_DOUT: rd_val = BUS_W'(dout_q);
            REG_OE:   rd_val = BUS_W'(oe_q);
            REG_IN:   rd_val = BUS_W'(lvl);
            REG_STAT: rd_val = BUS_W'(status_q);
            REG_POL0: rd_val = pol0_view;
            REG_EN:   rd_val = BUS_W'(en_q);
            REG_POL1: rd_val = pol1_view;
            REG_MUX:  rd_val = mux_q;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (req.rd)
            rdata <= rd_val;
    end

endmodule

// File: rtl/pinio_ctrl.sv
`timescale 1ns/1ps
module pinio_ctrl
    import pinio_pkg::*;
#(
    parameter int NUM_PINS    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [IDX_W-1:0]    bus_word,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] status_q;
    logic [NUM_PINS-1:0] en_q;
    logic [NUM_PINS-1:0] pol_q;
    logic [NUM_PINS-1:0] clr_mask;
    logic [BUS_W-1:0]    mux_q;

    pinio_sync #(
        .W      (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sync_lvl)
    );

    pinio_regs #(
        .NUM_PINS (NUM_PINS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .lvl       (sync_lvl),
        .status_q  (status_q),
        .dout_q    (pin_out),
        .oe_q      (pin_oe),
        .en_q      (en_q),
        .pol_q     (pol_q),
        .mux_q     (mux_q),
        .clr_mask  (clr_mask),
        .rdata     (bus_rdata)
    );

    pinio_irq #(
        .NUM_PINS (NUM_PINS)
    ) u_irq (
        .clk      (clk),
        .rst      (rst),
        .lvl      (sync_lvl),
        .pol      (pol_q),
        .clr_mask (clr_mask),
        .status_q (status_q)
    );

    assign irq = |(status_q & en_q);

endmodule

// File: rtl/pinio_ctrl_chk.sv
`timescale 1ns/1ps
module pinio_ctrl_chk
    import pinio_pkg::*;
#(
    parameter int NUM_PINS = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_sel,
    input logic                bus_we,
    input logic [IDX_W-1:0]    bus_word,
    input logic [BUS_W-1:0]    bus_wdata,
    input logic [BUS_W-1:0]    bus_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq,
    input logic [NUM_PINS-1:0] status_q,
    input logic [NUM_PINS-1:0] en_q,
    input logic [NUM_PINS-1:0] lvl,
    input logic [BUS_W-1:0]    mux_q
);

    logic                rst_d;
    logic                wr_any;
    logic                rd_any;
    logic [NUM_PINS-1:0] w1c;

    assign wr_any = bus_sel & bus_we;
    assign rd_any = bus_sel & ~bus_we;
    assign w1c    = (wr_any && bus_word == REG_STAT) ? bus_wdata[NUM_PINS-1:0] : '0;

    always_ff @(posedge clk)
        rst_d <= rst;

    always @(negedge clk) begin
        if (rst_d) begin
            assert_reset_state_R1: assert (pin_out == '0 && pin_oe == '0 && !irq
                                           && status_q == '0 && bus_rdata == '0);
        end
    end

    assert_dout_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_word == REG_DOUT) |=> pin_out == $past(bus_wdata[NUM_PINS-1:0]));

    assert_oe_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_word == REG_OE) |=> pin_oe == $past(bus_wdata[NUM_PINS-1:0]));

    assert_input_read_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_any && bus_word == REG_IN) |=> bus_rdata == BUS_W'($past(lvl)));

    assert_flag_held_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(status_q & ~w1c)) == $past(status_q & ~w1c)));

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq);

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status_q != '0));

    assert_mux_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_word == REG_MUX) |=> mux_q == $past(bus_wdata));

    assert_mux_read_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_any && bus_word == REG_MUX) |=> bus_rdata == $past(mux_q));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_any |=> $stable(bus_rdata));

endmodule

bind pinio_ctrl pinio_ctrl_chk #(
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .status_q  (status_q),
    .en_q      (en_q),
    .lvl       (sync_lvl),
    .mux_q     (mux_q)
);

// File: tb/test_pinio_ctrl.sv
`timescale 1ns/1ps
module test_pinio_ctrl;

    localparam int  NP   = 12;
    localparam time TCLK = 8ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0;
    logic          we = 1'b0;
    logic [2:0]    word = 3'd0;
    logic [31:0]   wdata = 32'd0;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;

    always #(TCLK/2) clk = ~clk;

    pinio_ctrl i_pinio_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (sel),
        .bus_we    (we),
        .bus_word  (word),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_dout, m_oe, m_en, m_t0, m_t1, m_mux, m_stat, m_rdata;
    logic [31:0] m_s1, m_s2;
    int          m_last_rd = -1;

    function automatic logic [31:0] m_read(int idx);
        case (idx)
            0: return m_dout;
            1: return m_oe;
            2: return m_s2;
            3: return m_stat;
            4: return m_t0;
            5: return m_en;
            6: return m_t1;
            default: return m_mux;
        endcase
    endfunction

    function automatic bit m_active_low(int line);
        if (line < 8)
            return m_t0[4*line];
        return m_t1[4*(line-8)];
    endfunction

    always @(posedge clk) begin
        logic [31:0] nstat;
        if (rst) begin
            m_dout = 0; m_oe = 0; m_en = 0; m_t0 = 0; m_t1 = 0;
            m_mux = 0; m_stat = 0; m_rdata = 0; m_s1 = 0; m_s2 = 0;
            m_last_rd = -1;
        end else begin
            if (sel && !we) begin
                m_rdata   = m_read(int'(word));
                m_last_rd = int'(word);
            end
            nstat = 0;
            for (int n = 0; n < NP; n++) begin
                bit lvl_on, clr;
                lvl_on = m_active_low(n) ? !m_s2[n] : m_s2[n];
                clr    = sel && we && word == 3'd3 && wdata[n];
                nstat[n] = lvl_on || (m_stat[n] && !clr);
            end
            m_stat = nstat;
            m_s2   = m_s1;
            m_s1   = 32'(pin_in);
            if (sel && we) begin
                case (word)
                    3'd0: m_dout = wdata & 32'h0000_0FFF;
                    3'd1: m_oe   = wdata & 32'h0000_0FFF;
                    3'd4: m_t0   = wdata & 32'h1111_1111;
                    3'd5: m_en   = wdata & 32'h0000_0FFF;
                    3'd6: m_t1   = wdata & 32'h0000_1111;
                    3'd7: m_mux  = wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic string rd_tag(int idx);
        case (idx)
            0, 1:    return "R2";
            2:       return "R3";
            3:       return "R5";
            4, 6:    return "R4";
            5:       return "R7";
            7:       return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // per-cycle comparison 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2ns;
            if (!rst) begin
                check("R2", 32'(pin_out), m_dout, "pin_out vs model");
                check("R2", 32'(pin_oe), m_oe, "pin_oe vs model");
                check("R7", 32'(irq), 32'((m_stat & m_en) != 0), "irq vs model");
                check("R9", rdata, m_rdata, {"rdata vs model, reg of ", rd_tag(m_last_rd)});
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(int idx, logic [31:0] v);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; word = 3'(idx); wdata = v;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; wdata = 32'd0;
    endtask

    task automatic bus_read(int idx, output logic [31:0] v);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; word = 3'(idx);
        @(negedge clk);
        sel = 1'b0;
        v = rdata;
    endtask

    task automatic expect_reg(string tag, int idx, logic [31:0] exp);
        logic [31:0] v;
        bus_read(idx, v);
        check(tag, v, exp, $sformatf("read word %0d", idx));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_pins(logic [NP-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        idle(3);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        check("R1", 32'(pin_out), 0, "pin_out after reset");
        check("R1", 32'(pin_oe), 0, "pin_oe after reset");
        check("R1", 32'(irq), 0, "irq after reset");
        for (int k = 0; k < 8; k++)
            expect_reg("R1", k, 32'd0);

        // R2: output data and drive-enable, upper bits dropped
        bus_write(0, 32'hFFFF_FABC);
        check("R2", 32'(pin_out), 32'h0000_0ABC, "pin_out after write");
        expect_reg("R2", 0, 32'h0000_0ABC);
        bus_write(1, 32'h8000_00F0);
        check("R2", 32'(pin_oe), 32'h0000_00F0, "pin_oe after write");
        expect_reg("R2", 1, 32'h0000_00F0);

        // R8: mux word keeps all 32 bits
        bus_write(7, 32'hDEAD_BEEF);
        expect_reg("R8", 7, 32'hDEAD_BEEF);

        // R4: only the polarity bits are stored
        bus_write(4, 32'hFFFF_FFFF);
        expect_reg("R4", 4, 32'h1111_1111);
        bus_write(6, 32'hFFFF_FFFF);
        expect_reg("R4", 6, 32'h0000_1111);

        // R5: all lines active-low with pins low -> all pending
        idle(3);
        expect_reg("R5", 3, 32'h0000_0FFF);
        check("R7", 32'(irq), 0, "irq with all lines masked");

        // R7: unmask line 0
        bus_write(5, 32'h0000_0001);
        check("R7", 32'(irq), 1, "irq after unmask of pending line 0");

        // R5: pins go inactive, flags stay latched
        drive_pins(12'hFFF);
        idle(4);
        expect_reg("R5", 3, 32'h0000_0FFF);

        // R6: write-one clears, write-zero leaves
        bus_write(3, 32'h0000_000F);
        expect_reg("R6", 3, 32'h0000_0FF0);
        bus_write(3, 32'h0000_0000);
        expect_reg("R6", 3, 32'h0000_0FF0);
        check("R7", 32'(irq), 0, "irq after clear of the only enabled line");

        // R6: clear while still active has no effect
        bus_write(4, 32'h0);
        bus_write(6, 32'h0);
        idle(3);
        bus_write(3, 32'h0000_0FFF);
        expect_reg("R6", 3, 32'h0000_0FFF);

        // R3: synchronized input, writes ignored
        drive_pins(12'h5A3);
        idle(3);
        bus_write(2, 32'hFFFF_FFFF);
        expect_reg("R3", 2, 32'h0000_05A3);

        // R4: per-bank polarity bit for lines 1 and 9
        drive_pins(12'h000);
        bus_write(4, 32'h0000_0010);
        bus_write(6, 32'h0000_0010);
        idle(4);
        bus_write(3, 32'h0000_0FFF);
        expect_reg("R4", 3, 32'h0000_0202);

        // R7: masked flags visible, enabled flag drives irq
        bus_write(5, 32'h0000_0200);
        check("R7", 32'(irq), 1, "irq from line 9");
        bus_write(5, 32'h0000_0000);
        check("R7", 32'(irq), 0, "irq after masking all");
        expect_reg("R7", 3, 32'h0000_0202);

        // R9: rdata holds with no request
        idle(5);
        check("R9", rdata, 32'h0000_0202, "rdata held while idle");

        idle(2);
        done = 1;
        summary();
        $finish;
    end

endmodule